// File: doc/BRIEF.md
# Effective address generator

This unit resolves the operand location of an 8-bit-data, 16-bit-address instruction. A request carries an addressing mode code, the address of the opcode byte (the program counter) and the two index registers. The unit then walks a small state machine that reads the operand bytes following the opcode and, for the indirect modes, the pointer bytes they refer to. All reads go through one byte-wide memory port, one byte per cycle. When the chain is complete it presents a 16-bit effective address, an operand kind and the instruction length in bytes, marked by a one-cycle done strobe.

The memory port is combinational from the unit's side: `mem_addr_o` and `mem_rd_o` are valid during a cycle and the byte on `mem_data_i` is taken at the end of that same cycle. Operand words are little-endian. Zero-page forms stay inside addresses 0x0000 to 0x00FF, while the absolute and post-indexed forms add the index over the full 16 bits. The operation itself and any extra cycles for page crossing belong to the consumer of the address.

Top module: `ea_gen`

## Requirements
- R1: A request (`req_i` high) is taken only on a clock edge at which `ready_o` is high, and mode, program counter and index values are captured then; `req_i` and all request inputs are ignored while `ready_o` is low. `done_o` is a one-cycle pulse, is high only while `ready_o` is high, and after reset `ready_o`=1, `done_o`=0, `mem_rd_o`=0.
- R2: Mode codes on `mode_i`: 0 implied, 1 accumulator, 2 immediate, 3 zero page, 4 zero page + X, 5 zero page + Y, 6 absolute, 7 absolute + X, 8 absolute + Y, 9 indirect, 10 pre-indexed indirect (X), 11 post-indexed indirect (Y), 12 relative. Implied and accumulator read no byte and return `ea_o`=0.
- R3: `kind_o` is 0 for a memory operand, 1 for immediate, 2 for accumulator, 3 for no operand (implied). `len_o` is 1 for implied and accumulator, 3 for absolute, indexed absolute and indirect, and 2 for all other modes.
- R4: Immediate mode returns `ea_o` = PC+1 (mod 65536) and reads no byte.
- R5: Zero-page modes read byte b1 at PC+1 and return {0x00, b1}, {0x00, (b1+X) mod 256} or {0x00, (b1+Y) mod 256}.
- R6: Absolute modes read b1 at PC+1 and b2 at PC+2 and return {b2,b1}, {b2,b1}+X or {b2,b1}+Y, the sum taken mod 65536.
- R7: Indirect mode forms pointer P={b2,b1} and returns {mem[P+1], mem[P]}, with P+1 carrying into the high byte.
- R8: Pre-indexed indirect forms z=(b1+X) mod 256 and returns {mem[(z+1) mod 256], mem[z]}, both in page zero.
- R9: Post-indexed indirect returns {mem[(b1+1) mod 256], mem[b1]} + Y, the sum taken mod 65536.
- R10: Relative mode returns PC+2 plus b1 read as a signed two's-complement byte, mod 65536.
- R11: `done_o` rises N+1 clock edges after the accepting edge, where N is the number of bytes read: 0 for implied, accumulator, immediate and unused codes, 1 for zero-page and relative modes, 2 for absolute modes, 3 for pre- and post-indexed indirect, 4 for indirect.
- R12: Mode codes 13 to 15 behave as implied: `kind_o`=3, `len_o`=1, `ea_o`=0, no read.
- R13: `mem_rd_o` is high for exactly N cycles per request, never while `ready_o` is high, and the byte is taken in the cycle it is addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a resolution |
| mode_i | input | 4 | Addressing mode code |
| pc_i | input | 16 | Address of the opcode byte |
| x_i | input | 8 | X index value |
| y_i | input | 8 | Y index value |
| ready_o | output | 1 | Unit idle, request may be taken |
| mem_rd_o | output | 1 | Memory read in this cycle |
| mem_addr_o | output | 16 | Memory read address |
| mem_data_i | input | 8 | Byte read from memory, same cycle |
| done_o | output | 1 | Result valid pulse |
| ea_o | output | 16 | Effective address |
| kind_o | output | 2 | Operand kind |
| len_o | output | 2 | Instruction length in bytes |

## Verification
Every result is due a fixed number of edges after the accepting edge, N+1 with N the byte count of the mode, so the bench counts edges from acceptance while sampling on falling edges and compares that count, the number of read cycles seen, and the address, kind and length against values computed from an arithmetic memory model. The sweep covers all sixteen mode codes against program counters at the top of the address space, index values 0x01, 0x80 and 0xFF, and memory contents keyed so that the first operand byte is 0xFF, which forces the page-zero wraps and the indirect pointer carry. Half the requests hold `req_i` high with a different mode while the unit is busy, and any recapture shows up in the same-cycle result.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 16;
  localparam int unsigned MW = 4;
  localparam int unsigned LW = 2;
  localparam int unsigned KW = 2;

  typedef enum logic [MW-1:0] {
    M_IMPL = 4'd0, M_ACC = 4'd1, M_IMM = 4'd2, M_ZP = 4'd3, M_ZPX = 4'd4,
    M_ZPY = 4'd5, M_ABS = 4'd6, M_ABSX = 4'd7, M_ABSY = 4'd8, M_IND = 4'd9,
    M_INDX = 4'd10, M_INDY = 4'd11, M_REL = 4'd12
  } mode_e;

  typedef enum logic [KW-1:0] {
    K_MEM = 2'd0, K_IMM = 2'd1, K_ACC = 2'd2, K_NONE = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_OPLO, S_OPHI, S_PTRLO, S_PTRHI, S_FIN
  } st_e;
endpackage

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int unsigned DW_P = DW,
  parameter int unsigned AW_P = AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [MW-1:0]   mode_i,
  input  logic [AW_P-1:0] pc_i,
  input  logic [DW_P-1:0] x_i,
  input  logic [DW_P-1:0] y_i,
  input  logic [DW_P-1:0] mem_data_i,
  output logic            ready_o,
  output logic            mem_rd_o,
  output logic [AW_P-1:0] mem_addr_o,
  output logic            fin_o,
  output logic [MW-1:0]   mode_o,
  output logic [AW_P-1:0] pc_o,
  output logic [DW_P-1:0] x_o,
  output logic [DW_P-1:0] y_o,
  output logic [DW_P-1:0] lo_o,
  output logic [DW_P-1:0] hi_o
);
  localparam int unsigned HW = AW_P - DW_P;

  st_e             st_q, st_d;
  logic [MW-1:0]   mode_q;
  logic [AW_P-1:0] pc_q, ptr_q;
  logic [DW_P-1:0] x_q, y_q, lo_q, hi_q;

  function automatic logic has_operand(input logic [MW-1:0] m);
    return m inside {M_ZP, M_ZPX, M_ZPY, M_ABS, M_ABSX, M_ABSY,
                     M_IND, M_INDX, M_INDY, M_REL};
  endfunction

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (req_i) st_d = has_operand(mode_i) ? S_OPLO : S_FIN;
      S_OPLO: begin
        if (mode_q inside {M_ABS, M_ABSX, M_ABSY, M_IND}) st_d = S_OPHI;
        else if (mode_q inside {M_INDX, M_INDY})          st_d = S_PTRLO;
        else                                              st_d = S_FIN;
      end
      S_OPHI:  st_d = (mode_q == M_IND) ? S_PTRLO : S_FIN;
      S_PTRLO: st_d = S_PTRHI;
      S_PTRHI: st_d = S_FIN;
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    mem_addr_o = '0;
    unique case (st_q)
      S_OPLO:  mem_addr_o = pc_q + AW_P'(1);
      S_OPHI:  mem_addr_o = pc_q + AW_P'(2);
      S_PTRLO: mem_addr_o = ptr_q;
      S_PTRHI: mem_addr_o = (mode_q == M_IND) ? ptr_q + AW_P'(1)
                          : {ptr_q[AW_P-1:DW_P], ptr_q[DW_P-1:0] + DW_P'(1)};
      default: mem_addr_o = '0;
    endcase
  end

  assign mem_rd_o = st_q inside {S_OPLO, S_OPHI, S_PTRLO, S_PTRHI};
  assign ready_o  = (st_q == S_IDLE);
  assign fin_o    = (st_q == S_FIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      mode_q <= '0;
      pc_q   <= '0;
      ptr_q  <= '0;
      x_q    <= '0;
      y_q    <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      st_q <= st_d;
      unique case (st_q)
        S_IDLE: if (req_i) begin
          mode_q <= mode_i;
          pc_q   <= pc_i;
          x_q    <= x_i;
          y_q    <= y_i;
        end
        S_OPLO: begin
          lo_q <= mem_data_i;
          if (mode_q == M_INDX) ptr_q <= {{HW{1'b0}}, mem_data_i + x_q};
          else                  ptr_q <= {{HW{1'b0}}, mem_data_i};
        end
        S_OPHI: begin
          hi_q  <= mem_data_i;
          ptr_q <= {mem_data_i, lo_q};
        end
        S_PTRLO: lo_q <= mem_data_i;
        S_PTRHI: hi_q <= mem_data_i;
        default: ;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign pc_o   = pc_q;
  assign x_o    = x_q;
  assign y_o    = y_q;
  assign lo_o   = lo_q;
  assign hi_o   = hi_q;
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int unsigned DW_P = DW,
  parameter int unsigned AW_P = AW
) (
  input  logic [MW-1:0]   mode_i,
  input  logic [AW_P-1:0] pc_i,
  input  logic [DW_P-1:0] x_i,
  input  logic [DW_P-1:0] y_i,
  input  logic [DW_P-1:0] lo_i,
  input  logic [DW_P-1:0] hi_i,
  output logic [AW_P-1:0] ea_o,
  output logic [KW-1:0]   kind_o,
  output logic [LW-1:0]   len_o
);
  localparam int unsigned HW = AW_P - DW_P;

  logic [AW_P-1:0] word;
  assign word = {hi_i, lo_i};

  always_comb begin
    ea_o   = '0;
    kind_o = K_MEM;
    len_o  = LW'(2);
    unique case (mode_i)
      M_ACC:  begin kind_o = K_ACC; len_o = LW'(1); end
      M_IMM:  begin kind_o = K_IMM; ea_o = pc_i + AW_P'(1); end
      M_ZP:   ea_o = {{HW{1'b0}}, lo_i};
      M_ZPX:  ea_o = {{HW{1'b0}}, lo_i + x_i};
      M_ZPY:  ea_o = {{HW{1'b0}}, lo_i + y_i};
      M_ABS:  begin ea_o = word;                       len_o = LW'(3); end
      M_ABSX: begin ea_o = word + {{HW{1'b0}}, x_i};   len_o = LW'(3); end
      M_ABSY: begin ea_o = word + {{HW{1'b0}}, y_i};   len_o = LW'(3); end
      M_IND:  begin ea_o = word;                       len_o = LW'(3); end
      M_INDX: ea_o = word;
      M_INDY: ea_o = word + {{HW{1'b0}}, y_i};
      M_REL:  ea_o = pc_i + AW_P'(2) + {{HW{lo_i[DW_P-1]}}, lo_i};
      default: begin kind_o = K_NONE; len_o = LW'(1); end
    endcase
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int unsigned DW_P = DW,
  parameter int unsigned AW_P = AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [MW-1:0]   mode_i,
  input  logic [AW_P-1:0] pc_i,
  input  logic [DW_P-1:0] x_i,
  input  logic [DW_P-1:0] y_i,
  output logic            ready_o,
  output logic            mem_rd_o,
  output logic [AW_P-1:0] mem_addr_o,
  input  logic [DW_P-1:0] mem_data_i,
  output logic            done_o,
  output logic [AW_P-1:0] ea_o,
  output logic [KW-1:0]   kind_o,
  output logic [LW-1:0]   len_o
);
  logic            fin;
  logic [MW-1:0]   mode_c;
  logic [AW_P-1:0] pc_c, ea_d;
  logic [DW_P-1:0] x_c, y_c, lo_c, hi_c;
  logic [KW-1:0]   kind_d;
  logic [LW-1:0]   len_d;

  ea_seq #(.DW_P(DW_P), .AW_P(AW_P)) u_seq (
    .clk_i, .rst_ni, .req_i, .mode_i, .pc_i, .x_i, .y_i, .mem_data_i,
    .ready_o, .mem_rd_o, .mem_addr_o,
    .fin_o(fin), .mode_o(mode_c), .pc_o(pc_c), .x_o(x_c), .y_o(y_c),
    .lo_o(lo_c), .hi_o(hi_c)
  );

  ea_calc #(.DW_P(DW_P), .AW_P(AW_P)) u_calc (
    .mode_i(mode_c), .pc_i(pc_c), .x_i(x_c), .y_i(y_c), .lo_i(lo_c),
    .hi_i(hi_c), .ea_o(ea_d), .kind_o(kind_d), .len_o(len_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      ea_o   <= '0;
      kind_o <= K_NONE;
      len_o  <= LW'(1);
    end else begin
      done_o <= fin;
      if (fin) begin
        ea_o   <= ea_d;
        kind_o <= kind_d;
        len_o  <= len_d;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk
  import ea_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [MW-1:0] mode_i,
  input logic          ready_o,
  input logic          mem_rd_o,
  input logic          done_o,
  input logic [15:0]   ea_o,
  input logic [KW-1:0] kind_o,
  input logic [LW-1:0] len_o
);
  logic [MW-1:0] mode_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               mode_c <= '0;
    else if (req_i && ready_o) mode_c <= mode_i;
  end

  p_idle_no_read_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_rd_o);

  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  p_zp_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (mode_c inside {M_ZP, M_ZPX, M_ZPY})) |-> (ea_o[15:8] == 8'h00));

  p_short_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (kind_o inside {K_ACC, K_NONE})) |-> (len_o == 2'd1));

  p_imm_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && kind_o == K_IMM) |-> (len_o == 2'd2));

  p_unused_none_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_c > 4'd12) |-> (kind_o == K_NONE && ea_o == 16'h0000));
endmodule

bind ea_gen ea_gen_chk u_chk (
  .clk_i, .rst_ni, .req_i, .mode_i, .ready_o, .mem_rd_o, .done_o,
  .ea_o, .kind_o, .len_o
);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  x_i = '0, y_i = '0;
  logic        ready_o, mem_rd_o, done_o;
  logic [15:0] mem_addr_o, ea_o;
  logic [7:0]  mem_data_i;
  logic [1:0]  kind_o, len_o;

  int n_vec = 0, n_err = 0;
  logic [7:0]  key = 8'h00;
  logic [31:0] lfsr = 32'h1234_5678;
  bit          hung = 1'b0;

  always #2.5 clk_i = ~clk_i;

  function automatic logic [7:0] mf(input logic [15:0] a, input logic [7:0] k);
    return a[7:0] ^ a[15:8] ^ k ^ {a[6:0], a[7]};
  endfunction

  assign mem_data_i = mf(mem_addr_o, key);

  ea_gen dut (.*);

  task automatic chk(input string tag, input bit ok, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  task automatic run_one(input logic [3:0] m, input logic [15:0] pc,
                         input logic [7:0] x, input logic [7:0] y,
                         input logic [7:0] k, input bit poke);
    logic [15:0] a1, a2, p, e_ea;
    logic [7:0]  b1, b2, z;
    int n, e_len, e_kind, cnt, nrd;
    string tag;
    a1 = pc + 16'd1; a2 = pc + 16'd2;
    b1 = mf(a1, k); b2 = mf(a2, k);
    e_ea = 16'h0; e_kind = 0; e_len = 2; n = 0;
    case (m)
      4'd1:  begin e_kind = 2; e_len = 1; tag = "R2 acc"; end
      4'd2:  begin e_kind = 1; e_ea = a1; tag = "R4 imm"; end
      4'd3:  begin n = 1; e_ea = {8'h00, b1}; tag = "R5 zp"; end
      4'd4:  begin n = 1; e_ea = {8'h00, 8'(b1 + x)}; tag = "R5 zpx"; end
      4'd5:  begin n = 1; e_ea = {8'h00, 8'(b1 + y)}; tag = "R5 zpy"; end
      4'd6:  begin n = 2; e_len = 3; e_ea = {b2, b1}; tag = "R6 abs"; end
      4'd7:  begin n = 2; e_len = 3; e_ea = {b2, b1} + {8'h00, x}; tag = "R6 absx"; end
      4'd8:  begin n = 2; e_len = 3; e_ea = {b2, b1} + {8'h00, y}; tag = "R6 absy"; end
      4'd9:  begin n = 4; e_len = 3; p = {b2, b1};
                   e_ea = {mf(p + 16'd1, k), mf(p, k)}; tag = "R7 ind"; end
      4'd10: begin n = 3; z = b1 + x;
                   e_ea = {mf({8'h00, 8'(z + 8'd1)}, k), mf({8'h00, z}, k)}; tag = "R8 indx"; end
      4'd11: begin n = 3;
                   e_ea = {mf({8'h00, 8'(b1 + 8'd1)}, k), mf({8'h00, b1}, k)} + {8'h00, y};
                   tag = "R9 indy"; end
      4'd12: begin n = 1; e_ea = a2 + {{8{b1[7]}}, b1}; tag = "R10 rel"; end
      4'd0:  begin e_kind = 3; e_len = 1; tag = "R2 impl"; end
      default: begin e_kind = 3; e_len = 1; tag = "R12 unused"; end
    endcase
    if (poke) tag = {"R1 ", tag};
    key = k;
    @(negedge clk_i);
    req_i = 1'b1; mode_i = m; pc_i = pc; x_i = x; y_i = y;
    @(negedge clk_i);
    cnt = 0; nrd = 0;
    req_i = poke;
    if (poke) begin mode_i = ~m; pc_i = ~pc; x_i = ~x; y_i = ~y; end
    while (!done_o && cnt < 20) begin
      if (mem_rd_o) nrd++;
      @(negedge clk_i);
      cnt++;
    end
    req_i = 1'b0;
    chk({tag, " ea"}, ea_o == e_ea, ea_o, e_ea);
    chk({"R3 kind ", tag}, kind_o == 2'(e_kind), kind_o, e_kind);
    chk({"R3 len ", tag}, len_o == 2'(e_len), len_o, e_len);
    chk({"R11 latency ", tag}, cnt == n + 1, cnt, n + 1);
    chk({"R13 reads ", tag}, nrd == n, nrd, n);
  endtask

  initial begin
    #400000;
    hung = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset ready", ready_o == 1'b1, ready_o, 1);
    chk("R1 reset done", done_o == 1'b0, done_o, 0);
    chk("R13 reset read", mem_rd_o == 1'b0, mem_rd_o, 0);
    rst_ni = 1'b1;
    for (int m = 0; m < 16 && !hung; m++) begin
      for (int i = 0; i < 24 && !hung; i++) begin
        logic [15:0] pc;
        logic [7:0]  x, y, k;
        step();
        pc = (i == 0) ? 16'hFFFF : (i == 1) ? 16'hFFFE : (i == 2) ? 16'h00FF : lfsr[15:0];
        case (i % 4)
          0: x = 8'hFF;
          1: x = 8'h01;
          2: x = 8'h80;
          default: x = lfsr[23:16];
        endcase
        case ((i + 1) % 4)
          0: y = 8'hFF;
          1: y = 8'h01;
          2: y = 8'h80;
          default: y = lfsr[31:24];
        endcase
        if (i < 8) begin
          logic [15:0] a1;
          a1 = pc + 16'd1;
          k = 8'hFF ^ a1[7:0] ^ a1[15:8] ^ {a1[6:0], a1[7]};
        end else k = lfsr[7:0] ^ lfsr[31:24];
        run_one(4'(m), pc, x, y, k, i[0]);
      end
    end
    if (hung) begin
      n_vec++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule